// File: doc/BRIEF.md
# Strobe-Gated Three-Tone Sine Source

This block produces a synthetic test signal for studying a 0 to 3400 Hz low-pass filter. A divider turns the fast system clock into a single-cycle sample strobe, one every 1000 clocks by default. With a 50 MHz clock that gives a 50 kHz sample rate. On each strobe, three 32-bit phase accumulators each add their own frequency code. The frequency of a channel is Fsam·L/2^32, so one code step is about 11.64 µHz. One channel carries the wanted tone (code 171798692 gives 2000 Hz). The other two carry sinusoidal interferers placed above the band (3500 Hz and 3900 Hz are typical), at the same amplitude as the wanted tone.

All three channels share one sine table. The table covers a full period in 16384 offset-binary 10-bit points. Only a quarter wave is stored, and the other three quadrants are rebuilt by mirroring the address and negating. After each strobe the single read port is used by each channel in turn. The per-channel samples are then combined into one word for a 10-bit DAC, and a valid pulse marks the moment all four outputs are fresh. The frequency codes and the per-channel enables are taken only at the strobe, so a change never splits a sample period.

Top module: `mtdds_source`

## Requirements
- R1: Synchronous active-high reset clears the accumulators and the strobe divider. While in reset and right after it, every sample output and `mix_out` read 512 and `samp_valid` is low.
- R2: `samp_valid` is a single-cycle pulse. Successive pulses are exactly CLK_DIV (1000) clocks apart.
- R3: At the n-th valid pulse after reset, with code L held at every strobe, a channel's sample equals T[a]. Here a is bits 31..18 of (n·L mod 2^32), and the accumulator wraps modulo 2^32.
- R4: T[i] = 512 + floor(511·sin(2π·i/16384)) for i in 0..16383. In particular T[0]=512, T[4096]=1023, T[8192]=512 and T[12288]=1.
- R5: Each frequency code is taken only at the strobe. A code that is changed and then restored between two strobes has no effect on any output.
- R6: Enable bits map as bit 0 for base, bit 1 for interferer 1 and bit 2 for interferer 2, and each bit is sampled at the strobe. A disabled channel outputs 512 and contributes nothing to `mix_out`.
- R7: `mix_out` = clamp(floor((s0−512 + s1−512 + s2−512) / 4) + 512, 0, 1023), computed from the three sample outputs of the same valid pulse.
- R8: `mix_out` changes only in a cycle where `samp_valid` is high. All outputs hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| code_base | input | 32 | Frequency code of the wanted tone |
| code_int1 | input | 32 | Frequency code of interferer 1 |
| code_int2 | input | 32 | Frequency code of interferer 2 |
| chan_en | input | 3 | Per-channel enable (bit 0 base, 1 int1, 2 int2) |
| samp_base | output | 10 | Offset-binary sample of the wanted tone |
| samp_int1 | output | 10 | Offset-binary sample of interferer 1 |
| samp_int2 | output | 10 | Offset-binary sample of interferer 2 |
| mix_out | output | 10 | Scaled, saturated sum for the DAC |
| samp_valid | output | 1 | One-cycle pulse when all outputs are updated |

## Verification
The main stimulus is a set of code triples.

- The 2000/3500/3900 Hz set spreads the table addresses over all quadrants.
- A code of 2^30 steps through the four quadrant boundary points, which checks the corrections at the mirror and zero-crossing points.
- An all-ones code exercises accumulator wrap and the last table entry.
- Equal codes on all channels drive the mix to its extremes and test the floor rounding of negative sums.

Directed tests then separate the sampling of codes at the strobe from combinational use, using a code glitch between strobes, and separate a disabled channel from a zero code.

// File: rtl/mtdds_pkg.sv
package mtdds_pkg;
  localparam int NCH       = 3;
  localparam int PHASE_W   = 32;
  localparam int ADDR_W    = 14;
  localparam int DATA_W    = 10;
  localparam int CLK_DIV   = 1000;
  localparam int MIX_SHIFT = 2;

  // Codes for a 50 kHz sample rate: round(f * 2^32 / 50000)
  localparam logic [PHASE_W-1:0] CODE_2000HZ = 32'd171798692;
  localparam logic [PHASE_W-1:0] CODE_3500HZ = 32'd300647711;
  localparam logic [PHASE_W-1:0] CODE_3900HZ = 32'd335007449;
endpackage

// File: rtl/mtdds_strobe.sv
module mtdds_strobe #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic stb
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      stb <= 1'b0;
    end else begin
      stb <= (cnt == LAST);
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mtdds_phase.sv
module mtdds_phase #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic [PHASE_W-1:0] code,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (stb) phase <= phase + code;
  end
endmodule

// File: rtl/mtdds_sine_rom.sv
module mtdds_sine_rom #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 10,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] dout,
  output logic              dout_v,
  output logic [TAG_W-1:0]  dout_tag
);
  localparam int QW     = ADDR_W - 2;
  localparam int QDEPTH = 2 ** QW;
  localparam int MAG_W  = DATA_W - 1;
  localparam int MID    = 2 ** (DATA_W - 1);
  localparam int AMP    = MID - 1;
  localparam real TWO_PI = 6.283185307179586;

  logic [MAG_W-1:0] mag_mem [QDEPTH+1];

  initial begin
    for (int k = 0; k <= QDEPTH; k++) begin
      mag_mem[k] = MAG_W'($rtoi($floor(real'(AMP) *
                   $sin(TWO_PI * real'(k) / real'(4 * QDEPTH)))));
    end
  end

  logic [1:0]    quad;
  logic [QW-1:0] low;
  logic [QW:0]   k_idx;
  logic          edge_pt;

  always_comb begin
    quad    = rd_addr[ADDR_W-1 -: 2];
    low     = rd_addr[QW-1:0];
    k_idx   = quad[0] ? ((QW+1)'(QDEPTH) - {1'b0, low}) : {1'b0, low};
    edge_pt = (k_idx == '0) || (k_idx == (QW+1)'(QDEPTH));
  end

  logic [MAG_W-1:0] mag_q;
  logic             neg_q, corr_q;

  always_ff @(posedge clk) begin
    mag_q <= mag_mem[k_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_v   <= 1'b0;
      dout_tag <= '0;
      neg_q    <= 1'b0;
      corr_q   <= 1'b0;
    end else begin
      dout_v   <= rd_en;
      dout_tag <= rd_tag;
      neg_q    <= quad[1];
      corr_q   <= quad[1] & ~edge_pt;
    end
  end

  // Negative half: floor(-x) = -(floor(x)+1) unless x is integral
  always_comb begin
    if (neg_q) dout = DATA_W'(MID) - {1'b0, mag_q} - DATA_W'(corr_q);
    else       dout = DATA_W'(MID) + {1'b0, mag_q};
  end
endmodule

// File: rtl/mtdds_mix.sv
module mtdds_mix #(
  parameter int NCH    = 3,
  parameter int DATA_W = 10,
  parameter int SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] samp [NCH],
  output logic [DATA_W-1:0] mix_q,
  output logic              valid_q
);
  localparam int MID   = 2 ** (DATA_W - 1);
  localparam int MAXV  = 2 ** DATA_W - 1;
  localparam int SUM_W = DATA_W + $clog2(NCH + 1) + 2;

  logic signed [SUM_W-1:0] acc, scaled;
  logic [DATA_W-1:0]       sat;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NCH; i++) begin
      acc = acc + signed'(SUM_W'(samp[i])) - SUM_W'(MID);
    end
    scaled = (acc >>> SHIFT) + SUM_W'(MID);
    if (scaled < 0)                        sat = '0;
    else if (scaled > SUM_W'(MAXV))        sat = DATA_W'(MAXV);
    else                                   sat = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mix_q   <= DATA_W'(MID);
      valid_q <= 1'b0;
    end else begin
      valid_q <= go;
      if (go) mix_q <= sat;
    end
  end
endmodule

// File: rtl/mtdds_source.sv
module mtdds_source
  import mtdds_pkg::*;
#(
  parameter int PHASE_W_P   = PHASE_W,
  parameter int ADDR_W_P    = ADDR_W,
  parameter int DATA_W_P    = DATA_W,
  parameter int CLK_DIV_P   = CLK_DIV,
  parameter int MIX_SHIFT_P = MIX_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PHASE_W_P-1:0] code_base,
  input  logic [PHASE_W_P-1:0] code_int1,
  input  logic [PHASE_W_P-1:0] code_int2,
  input  logic [NCH-1:0]       chan_en,
  output logic [DATA_W_P-1:0]  samp_base,
  output logic [DATA_W_P-1:0]  samp_int1,
  output logic [DATA_W_P-1:0]  samp_int2,
  output logic [DATA_W_P-1:0]  mix_out,
  output logic                 samp_valid
);
  localparam int SLOT_W = $clog2(NCH);
  localparam int MID    = 2 ** (DATA_W_P - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NCH - 1);

  logic                 stb;
  logic [PHASE_W_P-1:0] code_v  [NCH];
  logic [PHASE_W_P-1:0] phase_v [NCH];
  logic [NCH-1:0]       en_q;

  assign code_v[0] = code_base;
  assign code_v[1] = code_int1;
  assign code_v[2] = code_int2;

  mtdds_strobe #(.DIV(CLK_DIV_P)) u_stb (
    .clk(clk), .rst(rst), .stb(stb)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    mtdds_phase #(.PHASE_W(PHASE_W_P)) u_ph (
      .clk(clk), .rst(rst), .stb(stb), .code(code_v[g]), .phase(phase_v[g])
    );
  end

  // Table read sequencer: one channel per cycle after each strobe
  logic              rd_act;
  logic [SLOT_W-1:0] rd_slot;
  logic [ADDR_W_P-1:0] rd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act  <= 1'b0;
      rd_slot <= '0;
      en_q    <= '0;
    end else if (stb) begin
      rd_act  <= 1'b1;
      rd_slot <= '0;
      en_q    <= chan_en;
    end else if (rd_act) begin
      rd_slot <= rd_slot + 1'b1;
      if (rd_slot == LAST_SLOT) rd_act <= 1'b0;
    end
  end

  always_comb begin
    rd_addr = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_slot == SLOT_W'(i)) rd_addr = phase_v[i][PHASE_W_P-1 -: ADDR_W_P];
    end
  end

  logic [DATA_W_P-1:0] rom_d;
  logic                rom_v;
  logic [SLOT_W-1:0]   rom_tag;

  mtdds_sine_rom #(.ADDR_W(ADDR_W_P), .DATA_W(DATA_W_P), .TAG_W(SLOT_W)) u_rom (
    .clk(clk), .rst(rst), .rd_en(rd_act), .rd_addr(rd_addr), .rd_tag(rd_slot),
    .dout(rom_d), .dout_v(rom_v), .dout_tag(rom_tag)
  );

  logic [DATA_W_P-1:0] samp_q [NCH];
  logic                mix_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) samp_q[i] <= DATA_W_P'(MID);
      mix_go <= 1'b0;
    end else begin
      mix_go <= rom_v && (rom_tag == LAST_SLOT);
      if (rom_v) begin
        for (int i = 0; i < NCH; i++) begin
          if (rom_tag == SLOT_W'(i))
            samp_q[i] <= en_q[i] ? rom_d : DATA_W_P'(MID);
        end
      end
    end
  end

  mtdds_mix #(.NCH(NCH), .DATA_W(DATA_W_P), .SHIFT(MIX_SHIFT_P)) u_mix (
    .clk(clk), .rst(rst), .go(mix_go), .samp(samp_q),
    .mix_q(mix_out), .valid_q(samp_valid)
  );

  assign samp_base = samp_q[0];
  assign samp_int1 = samp_q[1];
  assign samp_int2 = samp_q[2];
endmodule

// File: rtl/mtdds_source_chk.sv
module mtdds_source_chk #(
  parameter int DATA_W = 10,
  parameter int DIV    = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              samp_valid,
  input logic [DATA_W-1:0] mix_out,
  input logic [DATA_W-1:0] samp_base,
  input logic [DATA_W-1:0] samp_int1,
  input logic [DATA_W-1:0] samp_int2
);
  localparam int MID = 2 ** (DATA_W - 1);

  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (samp_valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mix_out == DATA_W'(MID) && samp_base == DATA_W'(MID) && !samp_valid));

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    samp_valid |=> !samp_valid);

  // R2
  valid_period_chk: assert property (@(posedge clk) disable iff (rst)
    (samp_valid && seen) |-> (gap == 32'(DIV - 1)));

  // R8
  mix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !samp_valid |-> $stable(mix_out));

  // R4
  table_floor_chk: assert property (@(posedge clk) disable iff (rst)
    samp_valid |-> (samp_base != '0 && samp_int1 != '0 && samp_int2 != '0));
endmodule

bind mtdds_source mtdds_source_chk #(.DATA_W(DATA_W_P), .DIV(CLK_DIV_P)) u_chk (
  .clk(clk), .rst(rst), .samp_valid(samp_valid), .mix_out(mix_out),
  .samp_base(samp_base), .samp_int1(samp_int1), .samp_int2(samp_int2)
);

// File: tb/mtdds_source_test.sv
`timescale 1ns/1ps
module mtdds_source_test;
  import mtdds_pkg::*;

  localparam real PI2 = 6.283185307179586;
  localparam int  NV  = 6;

  localparam logic [31:0] V_C0 [NV] = '{CODE_2000HZ, 32'h4000_0000, 32'hFFFF_FFFF,
                                        CODE_2000HZ, 32'd0, 32'h4000_0000};
  localparam logic [31:0] V_C1 [NV] = '{CODE_3500HZ, 32'd0, 32'h8000_0000,
                                        CODE_3500HZ, 32'd0, 32'h4000_0000};
  localparam logic [31:0] V_C2 [NV] = '{CODE_3900HZ, 32'd0, 32'h4000_0001,
                                        CODE_3900HZ, 32'd0, 32'h4000_0000};
  localparam logic [2:0]  V_EN [NV] = '{3'b111, 3'b001, 3'b111, 3'b101, 3'b111, 3'b111};
  localparam int          V_N  [NV] = '{6, 4, 5, 4, 3, 4};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] code_base = '0, code_int1 = '0, code_int2 = '0;
  logic [2:0]  chan_en = '0;
  logic [9:0]  samp_base, samp_int1, samp_int2, mix_out;
  logic        samp_valid;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mtdds_source uut (
    .clk(clk), .rst(rst), .code_base(code_base), .code_int1(code_int1),
    .code_int2(code_int2), .chan_en(chan_en), .samp_base(samp_base),
    .samp_int1(samp_int1), .samp_int2(samp_int2), .mix_out(mix_out),
    .samp_valid(samp_valid)
  );

  function automatic int tab(input logic [31:0] ph);
    int i;
    i = int'(ph[31:18]);
    return 512 + $rtoi($floor(511.0 * $sin(PI2 * real'(i) / 16384.0)));
  endfunction

  function automatic int mixf(input int a, input int b, input int c);
    int s;
    s = (a + b + c - 1536) >>> 2;
    s = s + 512;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] c0, input logic [31:0] c1,
                          input logic [31:0] c2, input logic [2:0] en);
    @(negedge clk);
    rst = 1'b1;
    code_base = c0; code_int1 = c1; code_int2 = c2; chan_en = en;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int n;
    n = 0;
    @(negedge clk);
    while (!samp_valid && n < 1100) begin
      @(negedge clk);
      n++;
    end
    if (!samp_valid) check({req, " valid timeout"}, 0, 1);
  endtask

  task automatic check_all(input string req, input logic [31:0] p0, input logic [31:0] p1,
                           input logic [31:0] p2, input logic [2:0] en);
    int e0, e1, e2;
    e0 = en[0] ? tab(p0) : 512;
    e1 = en[1] ? tab(p1) : 512;
    e2 = en[2] ? tab(p2) : 512;
    check({req, " base"}, int'(samp_base), e0);
    check({req, " int1"}, int'(samp_int1), e1);
    check({req, " int2"}, int'(samp_int2), e2);
    check({req, " R7 mix"}, int'(mix_out), mixf(e0, e1, e2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] p0, p1, p2;
    logic [9:0]  h0, hm;
    int          gap;

    // R1: reset state, during and just after reset
    do_reset(CODE_2000HZ, CODE_3500HZ, CODE_3900HZ, 3'b111);
    check("R1 base", int'(samp_base), 512);
    check("R1 int1", int'(samp_int1), 512);
    check("R1 int2", int'(samp_int2), 512);
    check("R1 mix", int'(mix_out), 512);
    check("R1 valid", int'(samp_valid), 0);

    // R3, R4, R6, R7: vector table walk
    for (int v = 0; v < NV; v++) begin
      do_reset(V_C0[v], V_C1[v], V_C2[v], V_EN[v]);
      p0 = '0; p1 = '0; p2 = '0;
      for (int n = 1; n <= V_N[v]; n++) begin
        p0 = p0 + V_C0[v]; p1 = p1 + V_C1[v]; p2 = p2 + V_C2[v];
        wait_valid("R3");
        check_all($sformatf("R3 vec%0d n%0d", v, n), p0, p1, p2, V_EN[v]);
      end
    end

    // R4: quadrant boundary table points with a code of 2^30
    do_reset(32'h4000_0000, 32'd0, 32'd0, 3'b001);
    wait_valid("R4"); check("R4 T[4096]",  int'(samp_base), 1023);
    wait_valid("R4"); check("R4 T[8192]",  int'(samp_base), 512);
    wait_valid("R4"); check("R4 T[12288]", int'(samp_base), 1);
    wait_valid("R4"); check("R4 T[0]",     int'(samp_base), 512);

    // R2: single-cycle pulse and exact period
    do_reset(CODE_2000HZ, CODE_3500HZ, CODE_3900HZ, 3'b111);
    wait_valid("R2");
    gap = 0;
    @(negedge clk);
    gap++;
    check("R2 pulse width", int'(samp_valid), 0);
    while (!samp_valid && gap < 1100) begin
      @(negedge clk);
      gap++;
    end
    check("R2 period", gap, CLK_DIV);

    // R8: outputs hold between pulses
    h0 = samp_base; hm = mix_out;
    repeat (500) @(negedge clk);
    check("R8 base hold", int'(samp_base), int'(h0));
    check("R8 mix hold", int'(mix_out), int'(hm));

    // R5: code glitch between strobes is ignored; a lasting change applies at next strobe
    do_reset(CODE_2000HZ, CODE_3500HZ, CODE_3900HZ, 3'b111);
    p0 = CODE_2000HZ; p1 = CODE_3500HZ; p2 = CODE_3900HZ;
    wait_valid("R5");
    check_all("R5 first", p0, p1, p2, 3'b111);
    @(negedge clk);
    code_base = 32'h1234_5678; code_int1 = 32'h7777_0000; code_int2 = 32'hFFFF_0000;
    repeat (200) @(negedge clk);
    code_base = CODE_2000HZ; code_int1 = CODE_3500HZ; code_int2 = CODE_3900HZ;
    p0 = p0 + CODE_2000HZ; p1 = p1 + CODE_3500HZ; p2 = p2 + CODE_3900HZ;
    wait_valid("R5");
    check_all("R5 glitch ignored", p0, p1, p2, 3'b111);
    @(negedge clk);
    code_base = 32'h2000_0000;
    p0 = p0 + 32'h2000_0000; p1 = p1 + CODE_3500HZ; p2 = p2 + CODE_3900HZ;
    wait_valid("R5");
    check_all("R5 new code", p0, p1, p2, 3'b111);

    // R6: disabled channel with a nonzero code reads mid-scale
    do_reset(32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 3'b010);
    wait_valid("R6");
    check("R6 base off", int'(samp_base), 512);
    check("R6 int1 on", int'(samp_int1), 1023);
    check("R6 int2 off", int'(samp_int2), 512);
    check("R6 R7 mix", int'(mix_out), mixf(512, 1023, 512));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule